// File: doc/BRIEF.md
# DMA Request Pending and Chaining Unit

This block sits in front of a DMA transfer engine and decides which of its sixteen channels runs next. Thirty-two hardware request lines come in. Each line first passes through its own polarity setting. Every channel then picks one of the lines through a 6-bit selector. A rising edge of the corrected level on the selected line marks the channel as pending, provided the channel is enabled.

Pending channels are served one at a time, and the lowest channel number always wins. A grant stays in place until the transfer engine pulses `xferDone`. A completing channel can name a successor in its chain field. That successor becomes pending with no hardware request. It then waits for its turn in the normal priority order and is not served at once.

Software programs the block through a small write-only register port. Address 0 bit 0 is a software reset strobe. Address 1 holds the channel enable mask and address 2 holds the line polarity mask. Addresses 16+c hold the selector and chain field of channel c.

Top module: `dma_req_sched`

## Requirements
- R1: After reset no channel is pending (`pendOut` = 0), `grantValid` is 0, every channel is disabled and every line is active high.
- R2: Channel c becomes pending on a rising edge of request line `sel[c]`, where `sel[c]` is bits [5:0] written to address 16+c. This happens only if bit c of the enable mask (address 1) is 1. A selector value of 32 or more triggers nothing.
- R3: Writing 1 to bit L of address 2 makes line L active low. The edge is then detected on the inverted level, so a falling input edge triggers.
- R4: While no grant is held, the lowest-numbered pending channel is granted. Its number appears on `grantCh`, and its pending bit is cleared in the same cycle. The grant is held until `xferDone` is seen. The next grant comes no earlier than the cycle after that.
- R5: Bits [13:8] of address 16+c form the chain field of channel c. When c completes with a field value n in 1..16, channel n-1 becomes pending. A value of 0 or above 16 chains nothing.
- R6: A chain target whose enable bit is 0 is not made pending.
- R7: A chained channel is served in priority order with the other pending channels. When lines 1, 2, 4 and 5 rise together and channel 1 chains to channel 3, the grants come in the order 1, 2, 3, 4, 5.
- R8: A hardware request and a chain trigger that reach the same channel in the same cycle give a single grant. A request that arrives while the channel is already pending also gives a single grant.
- R9: Writing 1 to bit 0 of address 0 clears every pending bit, the grant and the edge history, and keeps the configuration. A line that already sits at its active level afterwards triggers nothing until it makes a new edge.
- R10: `xferDone` while no grant is held has no effect, and in particular chains nothing.
- R11: `doneValid` is 1 exactly when `xferDone` arrives during a grant, and `doneCh` then gives the completing channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 32 | Hardware request lines |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register write address |
| wrData | input | 32 | Register write data |
| xferDone | input | 1 | Transfer engine completion pulse |
| grantValid | output | 1 | A channel is granted |
| grantCh | output | 4 | Granted channel number |
| doneValid | output | 1 | Completion accepted this cycle |
| doneCh | output | 4 | Channel that completed |
| pendOut | output | 16 | Pending channel bits |

## Verification
The two functions that can hit the same channel in the same cycle are the hardware edge path and the chain path. The bench arranges for channel 7's line to rise one cycle before it pulses `xferDone` for channel 0, whose chain field names channel 7. Both set paths therefore write pending bit 7 on the same clock edge. The case is judged by counting grants: channel 7 must be granted exactly once, and no grant may follow.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int REQ_N    = 32;
  localparam int CH_N     = 16;
  localparam int SEL_W    = 6;
  localparam int CHAIN_W  = 6;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int CH_W     = $clog2(CH_N);
  localparam int REQ_W    = $clog2(REQ_N);
  localparam int CFG_BASE = 16;
  localparam int ADDR_RST = 0;
  localparam int ADDR_EN  = 1;
  localparam int ADDR_POL = 2;
  localparam int CHAIN_LO = 8;

  typedef struct packed {
    logic            take;
    logic [CH_W-1:0] takeCh;
    logic            finish;
    logic [CH_W-1:0] finishCh;
    logic            swRst;
  } ctl_t;
endpackage

// File: rtl/dma_sched_datapath.sv
module dma_sched_datapath
  import dma_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REQ_N-1:0]  reqIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctl_t              ctl,
  output logic [CH_N-1:0]   pend
);
  logic [CH_N-1:0]    chEn;
  logic [REQ_N-1:0]   polLow;
  logic [SEL_W-1:0]   selReg   [CH_N];
  logic [CHAIN_W-1:0] chainReg [CH_N];
  logic               cfgHit;
  logic [CH_W-1:0]    cfgIdx;

  assign cfgHit = wrEn && (wrAddr >= ADDR_W'(CFG_BASE));
  assign cfgIdx = CH_W'(wrAddr - ADDR_W'(CFG_BASE));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chEn   <= '0;
      polLow <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_EN))  chEn   <= wrData[CH_N-1:0];
      if (wrAddr == ADDR_W'(ADDR_POL)) polLow <= wrData[REQ_N-1:0];
    end
  end

  // Edge history: two level stages plus a two-bit arming shift
  logic [REQ_N-1:0] lvlQ, lvlQQ, rise;
  logic [1:0]       armQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ  <= '0;
      lvlQQ <= '0;
      armQ  <= '0;
    end else if (ctl.swRst) begin
      lvlQ  <= '0;
      lvlQQ <= '0;
      armQ  <= '0;
    end else begin
      lvlQ  <= reqIn ^ polLow;
      lvlQQ <= lvlQ;
      armQ  <= {armQ[0], 1'b1};
    end
  end

  assign rise = armQ[1] ? (lvlQ & ~lvlQQ) : '0;

  logic [CH_N-1:0] hwTrig;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selReg[c]   <= '0;
        chainReg[c] <= '0;
      end else if (cfgHit && cfgIdx == CH_W'(c)) begin
        selReg[c]   <= wrData[SEL_W-1:0];
        chainReg[c] <= wrData[CHAIN_LO +: CHAIN_W];
      end
    end
    assign hwTrig[c] = chEn[c] && (selReg[c] < SEL_W'(REQ_N)) &&
                       rise[selReg[c][REQ_W-1:0]];
  end

  logic [CHAIN_W-1:0] chainField;
  logic [CH_W-1:0]    chainTgt;
  logic [CH_N-1:0]    chainSet, clrMask;

  assign chainField = chainReg[ctl.finishCh];
  assign chainTgt   = CH_W'(chainField - CHAIN_W'(1));

  always_comb begin
    chainSet = '0;
    if (ctl.finish && chainField != '0 && chainField <= CHAIN_W'(CH_N))
      chainSet[chainTgt] = chEn[chainTgt];
  end

  always_comb begin
    clrMask = '0;
    if (ctl.take) clrMask[ctl.takeCh] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pend <= '0;
    else if (ctl.swRst) pend <= '0;
    else                pend <= (pend & ~clrMask) | hwTrig | chainSet;
  end

  // R4
  take_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> pend[ctl.takeCh]);

  // R4
  take_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> ((pend & ((CH_N'(1) << ctl.takeCh) - CH_N'(1))) == '0));

  // R6
  disabled_never_pends_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pend & ~$past(pend) & ~$past(chEn)) == '0));

  // R9
  swrst_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.swRst |=> (pend == '0));
endmodule

// File: rtl/dma_sched_control.sv
module dma_sched_control
  import dma_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_N-1:0]   pend,
  input  logic              xferDone,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctl_t              ctl,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantCh
);
  logic [CH_W-1:0] pick;
  logic            swRst;

  always_comb begin
    pick = '0;
    for (int i = CH_N - 1; i >= 0; i--)
      if (pend[i]) pick = CH_W'(i);
  end

  assign swRst = wrEn && (wrAddr == ADDR_W'(ADDR_RST)) && wrData[0];

  assign ctl.swRst    = swRst;
  assign ctl.take     = !grantValid && (pend != '0) && !swRst;
  assign ctl.takeCh   = pick;
  assign ctl.finish   = grantValid && xferDone && !swRst;
  assign ctl.finishCh = grantCh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantCh    <= '0;
    end else if (swRst) begin
      grantValid <= 1'b0;
    end else if (ctl.take) begin
      grantValid <= 1'b1;
      grantCh    <= pick;
    end else if (ctl.finish) begin
      grantValid <= 1'b0;
    end
  end

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !xferDone && !swRst) |=> (grantValid && $stable(grantCh)));

  // R4
  regrant_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && xferDone) |=> !grantValid);
endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched
  import dma_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REQ_N-1:0]  reqIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              xferDone,
  output logic              grantValid,
  output logic [CH_W-1:0]   grantCh,
  output logic              doneValid,
  output logic [CH_W-1:0]   doneCh,
  output logic [CH_N-1:0]   pendOut
);
  ctl_t ctl;

  dma_sched_datapath dp_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .ctl(ctl), .pend(pendOut)
  );

  dma_sched_control ctl_i (
    .clk(clk), .rstN(rstN), .pend(pendOut), .xferDone(xferDone),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ctl(ctl),
    .grantValid(grantValid), .grantCh(grantCh)
  );

  // R11
  assign doneValid = ctl.finish;
  assign doneCh    = ctl.finishCh;
endmodule

// File: tb/dma_req_sched_tb.sv
module dma_req_sched_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        xferDone = 1'b0;
  logic        grantValid, doneValid;
  logic [3:0]  grantCh, doneCh;
  logic [15:0] pendOut;
  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  dma_req_sched dut_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .xferDone(xferDone), .grantValid(grantValid),
    .grantCh(grantCh), .doneValid(doneValid), .doneCh(doneCh), .pendOut(pendOut)
  );

  task automatic chk(string tag, int got, int exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(addr); wrData = 32'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfgCh(int ch, int sel, int chain);
    wr(16 + ch, (chain << 8) | sel);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitGrant(output int ch);
    ch = -1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (grantValid) begin
        ch = int'(grantCh);
        break;
      end
    end
  endtask

  task automatic pulseDone();
    @(negedge clk);
    xferDone = 1'b1;
    #1;
    chk("R11 doneValid", int'(doneValid), 1);
    chk("R11 doneCh", int'(doneCh), int'(grantCh));
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int ch;
    int exp;
    int order [5];
    idle(3);
    chk("R1 pend", int'(pendOut), 0);
    chk("R1 grant", int'(grantValid), 0);
    rstN = 1'b1;
    idle(2);
    chk("R1 pend after release", int'(pendOut), 0);

    // R2 sweep: identity mapping, every line
    wr(1, 32'hFFFF);
    for (int c = 0; c < 16; c++) cfgCh(c, c, 0);
    idle(3);
    for (int l = 0; l < 32; l++) begin
      @(negedge clk); reqIn = 32'(1) << l;
      waitGrant(ch);
      exp = (l < 16) ? l : -1;
      chk("R2 identity sweep", ch, exp);
      if (ch >= 0) begin
        chk("R4 pend cleared on grant", int'(pendOut), 0);
        idle(2);
        chk("R4 grant held", int'(grantValid), 1);
        pulseDone();
      end
      reqIn = '0;
      idle(3);
    end

    // R2 sweep: reversed mapping onto the upper lines
    for (int c = 0; c < 16; c++) cfgCh(c, 31 - c, 0);
    idle(3);
    for (int l = 0; l < 32; l++) begin
      @(negedge clk); reqIn = 32'(1) << l;
      waitGrant(ch);
      exp = (l >= 16) ? 31 - l : -1;
      chk("R2 reversed sweep", ch, exp);
      if (ch >= 0) pulseDone();
      reqIn = '0;
      idle(3);
    end

    // R2 selector out of range, and disabled channel
    cfgCh(0, 40, 0);
    @(negedge clk); reqIn = 32'h8000_0000;
    waitGrant(ch);
    chk("R2 selector >=32", ch, -1);
    reqIn = '0; idle(3);
    cfgCh(0, 0, 0);
    for (int c = 1; c < 16; c++) cfgCh(c, c, 0);
    wr(1, 32'hFFFE);
    @(negedge clk); reqIn = 32'h1;
    waitGrant(ch);
    chk("R2 disabled channel", ch, -1);
    reqIn = '0; idle(3);
    wr(1, 32'hFFFF);

    // R7 ordering with a chain from 1 to 3
    cfgCh(1, 1, 4);
    @(negedge clk); reqIn = 32'h36;
    for (int i = 0; i < 5; i++) begin
      waitGrant(ch);
      order[i] = ch;
      if (i == 0) chk("R4 pend while 1 granted", int'(pendOut), 32'h34);
      pulseDone();
      if (i == 0) chk("R5 chained 3 captured", int'(pendOut), 32'h3C);
    end
    for (int i = 0; i < 5; i++) chk("R7 service order", order[i], (i < 2) ? i + 1 : i + 1);
    waitGrant(ch);
    chk("R7 nothing after", ch, -1);
    reqIn = '0; idle(3);

    // R6 chain target disabled
    wr(1, 32'hFFF7);
    @(negedge clk); reqIn = 32'h36;
    for (int i = 0; i < 4; i++) begin
      waitGrant(ch);
      chk("R6 order without 3", ch, (i < 2) ? i + 1 : i + 2);
      pulseDone();
    end
    waitGrant(ch);
    chk("R6 no chained grant", ch, -1);
    reqIn = '0; idle(3);
    wr(1, 32'hFFFF);

    // R5 chain values 0 and 20 chain nothing
    cfgCh(1, 1, 0);
    @(negedge clk); reqIn = 32'h2;
    waitGrant(ch); chk("R5 chain 0 parent", ch, 1); pulseDone();
    waitGrant(ch); chk("R5 chain 0 none", ch, -1);
    reqIn = '0; idle(3);
    cfgCh(1, 1, 20);
    @(negedge clk); reqIn = 32'h2;
    waitGrant(ch); chk("R5 chain 20 parent", ch, 1); pulseDone();
    waitGrant(ch); chk("R5 chain 20 none", ch, -1);
    reqIn = '0; idle(3);
    cfgCh(1, 1, 16);
    @(negedge clk); reqIn = 32'h2;
    waitGrant(ch); pulseDone();
    waitGrant(ch); chk("R5 chain 16 to ch15", ch, 15); pulseDone();
    reqIn = '0; idle(3);
    cfgCh(1, 1, 0);

    // R8 hardware edge and chain trigger in the same cycle
    cfgCh(0, 0, 8);
    @(negedge clk); reqIn = 32'h1;
    waitGrant(ch); chk("R8 parent", ch, 0);
    reqIn[7] = 1'b1;
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    chk("R8 single pending bit", int'(pendOut), 32'h80);
    waitGrant(ch); chk("R8 merged grant", ch, 7); pulseDone();
    waitGrant(ch); chk("R8 only one grant", ch, -1);
    reqIn = '0; idle(3);
    cfgCh(0, 0, 0);

    // R8 second edge while already pending
    @(negedge clk); reqIn = 32'h1;
    waitGrant(ch);
    @(negedge clk); reqIn[3] = 1'b1;
    idle(3); reqIn[3] = 1'b0;
    idle(3); reqIn[3] = 1'b1;
    idle(3);
    chk("R8 merged pending", int'(pendOut), 32'h8);
    pulseDone();
    waitGrant(ch); chk("R8 merged served", ch, 3); pulseDone();
    waitGrant(ch); chk("R8 merged once", ch, -1);
    reqIn = '0; idle(3);

    // R10 completion without a grant
    cfgCh(0, 0, 3);
    cfgCh(15, 15, 3);
    @(negedge clk); xferDone = 1'b1;
    #1 chk("R10 doneValid idle", int'(doneValid), 0);
    @(negedge clk); xferDone = 1'b0;
    waitGrant(ch);
    chk("R10 no chain from idle done", ch, -1);
    chk("R10 pend idle", int'(pendOut), 0);
    cfgCh(0, 0, 0);
    cfgCh(15, 15, 0);

    // R3 and R9 polarity on line 6
    @(negedge clk); reqIn[6] = 1'b1;
    waitGrant(ch);
    if (ch >= 0) pulseDone();
    wr(2, 32'h40);
    wr(0, 1);
    idle(6);
    chk("R9 no spurious after reset", int'(grantValid), 0);
    chk("R9 pend after reset", int'(pendOut), 0);
    @(negedge clk); reqIn[6] = 1'b0;
    waitGrant(ch);
    chk("R3 active low trigger", ch, 6);
    @(negedge clk); reqIn[9] = 1'b1;
    idle(4);
    chk("R4 pend while held", int'(pendOut), 32'h200);
    wr(0, 1);
    chk("R9 pend cleared", int'(pendOut), 0);
    chk("R9 grant cleared", int'(grantValid), 0);
    idle(6);
    chk("R9 level without edge", int'(pendOut), 0);
    chk("R9 no grant without edge", int'(grantValid), 0);
    @(negedge clk); reqIn[9] = 1'b0;
    idle(3); reqIn[9] = 1'b1;
    waitGrant(ch);
    chk("R9 config kept", ch, 9);
    pulseDone();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule